// File: doc/BRIEF.md
# Translation Page Permission Checker

This block sits after a translation-table lookup. It judges one bus transaction against the permission fields of the entry that matched. Each valid transaction is decoded into a read, a write or an instruction fetch, and its privilege level is found. The block then tests the transaction against two layers of rules. The first layer is the six base read/write/execute grants, one set for supervisor and one for user. The second layer is a four-bit field of extra denials and a prefetch-allow gate.

One cycle later the block gives its verdict. Either pass is raised and the translated address and attributes go forward, or flush is raised and a downstream stage must turn the transaction into an error response. The first failure raises a sticky interrupt and captures a cause vector. Failures that arrive while the interrupt is pending only increment a saturating counter. A clear strobe from software releases the interrupt.

Top module: `perm_gate`

## Requirements
- R1: The privilege level is taken from inPriv bit 0 (1 = supervisor, 0 = user). The access is decoded from inDtype bit 0 and inDir: 0/1 is a read, 0/0 is a write, 1/1 is a fetch. permBits is laid out as [0] user read, [1] user write, [2] user fetch, [3] supervisor read, [4] supervisor write, [5] supervisor fetch. The transaction fails when the selected bit is 0.
- R2: The combination inDtype bit 0 = 1 with inDir = 0 always fails the base check.
- R3: When extraPerm[0] is 0, a transaction with inPriv equal to zero fails. A transaction with any nonzero inPriv is not affected by this bit.
- R4: When extraPerm[1] is 1, every write fails.
- R5: When extraPerm[2] is 1, every transaction with inDtype bit 0 = 1 fails.
- R6: When extraPerm[3] is 1, a transaction with inDtype bit 0 = 1 and nonzero inPriv fails. A fetch with inPriv equal to zero is not affected by this bit.
- R7: When inPfable is 1 and prefetchOk is 0, the transaction fails. When prefetchOk is 1, prefetchable transactions are not affected.
- R8: A valid transaction yields exactly one of outPass and outFlush in the next cycle. In that cycle outAddr and the attribute outputs carry the values presented with it. With no valid input, both outPass and outFlush are 0 in the next cycle.
- R9: The first failure sets irq in the same cycle as outFlush. It loads causeReg with every reason that applied, using bit [0] base, [1] user denied, [2] write denied, [3] fetch denied, [4] supervisor fetch denied, [5] prefetch denied. irq stays set until irqClear.
- R10: While irq is set, further failures leave causeReg unchanged and increment faultCount, which saturates at its all-ones value. Passing transactions do not increment it.
- R11: irqClear with no failure in the same cycle clears irq, causeReg and faultCount. When irqClear and a failure land together, the new failure's cause is captured, irq stays set and faultCount becomes 0.
- R12: After reset, outPass, outFlush, irq, causeReg and faultCount are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Transaction present this cycle |
| inPriv | input | PRIV_W | Privilege level of the transaction |
| inDtype | input | DTYPE_W | Data type; bit 0 marks an instruction fetch |
| inDir | input | 1 | Direction, 1 = toward requester (read/fetch) |
| inPfable | input | 1 | Transaction is prefetchable |
| inAddr | input | ADDR_W | Translated address |
| permBits | input | 6 | Base grants, layout in R1 |
| extraPerm | input | 4 | Extra denial field |
| prefetchOk | input | 1 | Prefetchable transactions permitted |
| irqClear | input | 1 | Software clear strobe for the fault interrupt |
| outPass | output | 1 | Transaction allowed; outputs below are forwarded |
| outFlush | output | 1 | Transaction invalidated |
| outAddr | output | ADDR_W | Registered address |
| outPriv | output | PRIV_W | Registered privilege |
| outDtype | output | DTYPE_W | Registered data type |
| outDir | output | 1 | Registered direction |
| outPfable | output | 1 | Registered prefetchable flag |
| irq | output | 1 | Sticky fault interrupt |
| causeReg | output | 6 | Captured cause of the first fault |
| faultCount | output | CNT_W | Faults seen while irq was pending |

## Verification
The interrupt clear from software and a newly registered failure can hit the same clock edge. That edge decides whether the block loses a fault or keeps a stale cause. The bench first leaves a fault pending with a known cause and a nonzero count. It then drives irqClear together with a transaction that fails for a different reason. It expects irq to remain set, causeReg to hold the new reason only, and faultCount to read zero. A follow-up plain clear must then empty all three.

// File: rtl/perm_gate_pkg.sv
package perm_gate_pkg;
  localparam int CAUSE_W = 6;
  localparam int CZ_BASE = 0;
  localparam int CZ_USER = 1;
  localparam int CZ_WRITE = 2;
  localparam int CZ_EXEC = 3;
  localparam int CZ_SUPX = 4;
  localparam int CZ_PREF = 5;

  typedef logic [CAUSE_W-1:0] cause_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_BAD   = 2'd3
  } access_e;

  typedef struct packed {
    logic   launch;
    logic   fault;
    logic   latchCause;
    logic   bumpCount;
    logic   wipe;
    cause_t cause;
  } ctlStrobe_t;
endpackage

// File: rtl/perm_gate_ctrl.sv
module perm_gate_ctrl
  import perm_gate_pkg::*;
#(
  parameter int PRIV_W = 2,
  parameter int DTYPE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [PRIV_W-1:0]  inPriv,
  input  logic [DTYPE_W-1:0] inDtype,
  input  logic               inDir,
  input  logic               inPfable,
  input  logic [5:0]         permBits,
  input  logic [3:0]         extraPerm,
  input  logic               prefetchOk,
  input  logic               irqClear,
  output ctlStrobe_t         strobe,
  output logic               irq
);
  access_e access;
  logic [2:0] grantSet;
  logic baseOk;
  logic isUser;
  logic isFetch;
  cause_t cause;

  always_comb begin
    unique case ({inDtype[0], inDir})
      2'b01:   access = ACC_READ;
      2'b00:   access = ACC_WRITE;
      2'b11:   access = ACC_EXEC;
      default: access = ACC_BAD;
    endcase
  end

  assign grantSet = inPriv[0] ? permBits[5:3] : permBits[2:0];
  assign isUser = (inPriv == '0);
  assign isFetch = inDtype[0];

  always_comb begin
    unique case (access)
      ACC_READ:  baseOk = grantSet[0];
      ACC_WRITE: baseOk = grantSet[1];
      ACC_EXEC:  baseOk = grantSet[2];
      default:   baseOk = 1'b0;
    endcase
  end

  always_comb begin
    cause = '0;
    cause[CZ_BASE]  = !baseOk;
    cause[CZ_USER]  = !extraPerm[0] && isUser;
    cause[CZ_WRITE] = extraPerm[1] && (access == ACC_WRITE);
    cause[CZ_EXEC]  = extraPerm[2] && isFetch;
    cause[CZ_SUPX]  = extraPerm[3] && isFetch && !isUser;
    cause[CZ_PREF]  = inPfable && !prefetchOk;
  end

  always_comb begin
    strobe.launch     = inValid;
    strobe.fault      = inValid && (cause != '0);
    strobe.cause      = cause;
    strobe.latchCause = strobe.fault && (!irq || irqClear);
    strobe.bumpCount  = strobe.fault && irq && !irqClear;
    strobe.wipe       = irqClear && !strobe.fault;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else if (strobe.latchCause) irq <= 1'b1;
    else if (strobe.wipe) irq <= 1'b0;
  end
endmodule

// File: rtl/perm_gate_dp.sv
module perm_gate_dp
  import perm_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PRIV_W = 2,
  parameter int DTYPE_W = 2,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  inAddr,
  input  logic [PRIV_W-1:0]  inPriv,
  input  logic [DTYPE_W-1:0] inDtype,
  input  logic               inDir,
  input  logic               inPfable,
  output logic               outPass,
  output logic               outFlush,
  output logic [ADDR_W-1:0]  outAddr,
  output logic [PRIV_W-1:0]  outPriv,
  output logic [DTYPE_W-1:0] outDtype,
  output logic               outDir,
  output logic               outPfable,
  output cause_t             causeReg,
  output logic [CNT_W-1:0]   faultCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outPass  <= 1'b0;
      outFlush <= 1'b0;
    end else begin
      outPass  <= strobe.launch && !strobe.fault;
      outFlush <= strobe.fault;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr   <= '0;
      outPriv   <= '0;
      outDtype  <= '0;
      outDir    <= 1'b0;
      outPfable <= 1'b0;
    end else if (strobe.launch) begin
      outAddr   <= inAddr;
      outPriv   <= inPriv;
      outDtype  <= inDtype;
      outDir    <= inDir;
      outPfable <= inPfable;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeReg   <= '0;
      faultCount <= '0;
    end else if (strobe.latchCause) begin
      causeReg   <= strobe.cause;
      faultCount <= '0;
    end else if (strobe.bumpCount) begin
      if (faultCount != CNT_MAX) faultCount <= faultCount + 1'b1;
    end else if (strobe.wipe) begin
      causeReg   <= '0;
      faultCount <= '0;
    end
  end
endmodule

// File: rtl/perm_gate.sv
module perm_gate
  import perm_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PRIV_W = 2,
  parameter int DTYPE_W = 2,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [PRIV_W-1:0]  inPriv,
  input  logic [DTYPE_W-1:0] inDtype,
  input  logic               inDir,
  input  logic               inPfable,
  input  logic [ADDR_W-1:0]  inAddr,
  input  logic [5:0]         permBits,
  input  logic [3:0]         extraPerm,
  input  logic               prefetchOk,
  input  logic               irqClear,
  output logic               outPass,
  output logic               outFlush,
  output logic [ADDR_W-1:0]  outAddr,
  output logic [PRIV_W-1:0]  outPriv,
  output logic [DTYPE_W-1:0] outDtype,
  output logic               outDir,
  output logic               outPfable,
  output logic               irq,
  output logic [5:0]         causeReg,
  output logic [CNT_W-1:0]   faultCount
);
  ctlStrobe_t strobe;

  perm_gate_ctrl #(.PRIV_W(PRIV_W), .DTYPE_W(DTYPE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPriv(inPriv),
    .inDtype(inDtype), .inDir(inDir), .inPfable(inPfable),
    .permBits(permBits), .extraPerm(extraPerm), .prefetchOk(prefetchOk),
    .irqClear(irqClear), .strobe(strobe), .irq(irq)
  );

  perm_gate_dp #(.ADDR_W(ADDR_W), .PRIV_W(PRIV_W), .DTYPE_W(DTYPE_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAddr(inAddr),
    .inPriv(inPriv), .inDtype(inDtype), .inDir(inDir), .inPfable(inPfable),
    .outPass(outPass), .outFlush(outFlush), .outAddr(outAddr),
    .outPriv(outPriv), .outDtype(outDtype), .outDir(outDir),
    .outPfable(outPfable), .causeReg(causeReg), .faultCount(faultCount)
  );
endmodule

// File: rtl/perm_gate_chk.sv
module perm_gate_chk #(
  parameter int ADDR_W = 32,
  parameter int PRIV_W = 2,
  parameter int DTYPE_W = 2,
  parameter int CNT_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [PRIV_W-1:0]  inPriv,
  input logic [DTYPE_W-1:0] inDtype,
  input logic               inDir,
  input logic               inPfable,
  input logic [ADDR_W-1:0]  inAddr,
  input logic [3:0]         extraPerm,
  input logic               prefetchOk,
  input logic               irqClear,
  input logic               outPass,
  input logic               outFlush,
  input logic [ADDR_W-1:0]  outAddr,
  input logic               irq,
  input logic [5:0]         causeReg,
  input logic [CNT_W-1:0]   faultCount
);
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ($countones({outPass, outFlush}) == 1)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outPass && !outFlush)); // R8
  AST_ADDR_FWD: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outAddr == $past(inAddr))); // R8
  AST_USER_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !extraPerm[0] && inPriv == '0) |=> outFlush); // R3
  AST_WRITE_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && extraPerm[1] && !inDtype[0] && !inDir) |=> outFlush); // R4
  AST_PREF_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inPfable && !prefetchOk) |=> outFlush); // R7
  AST_FLUSH_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    outFlush |-> (irq && causeReg != '0)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClear) |=> irq); // R9
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClear) |=> $stable(causeReg)); // R10
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !inValid) |=> (!irq && causeReg == '0 && faultCount == '0)); // R11
endmodule

bind perm_gate perm_gate_chk #(
  .ADDR_W(ADDR_W), .PRIV_W(PRIV_W), .DTYPE_W(DTYPE_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inPriv(inPriv),
  .inDtype(inDtype), .inDir(inDir), .inPfable(inPfable), .inAddr(inAddr),
  .extraPerm(extraPerm), .prefetchOk(prefetchOk), .irqClear(irqClear),
  .outPass(outPass), .outFlush(outFlush), .outAddr(outAddr), .irq(irq),
  .causeReg(causeReg), .faultCount(faultCount)
);

// File: tb/perm_gate_tb_top.sv
module perm_gate_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] inPriv = '0;
  logic [1:0] inDtype = '0;
  logic inDir = 1'b0;
  logic inPfable = 1'b0;
  logic [31:0] inAddr = '0;
  logic [5:0] permBits = '0;
  logic [3:0] extraPerm = '0;
  logic prefetchOk = 1'b0;
  logic irqClear = 1'b0;
  logic outPass, outFlush, outDir, outPfable, irq;
  logic [31:0] outAddr;
  logic [1:0] outPriv, outDtype;
  logic [5:0] causeReg;
  logic [3:0] faultCount;
  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  perm_gate dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPriv(inPriv),
    .inDtype(inDtype), .inDir(inDir), .inPfable(inPfable), .inAddr(inAddr),
    .permBits(permBits), .extraPerm(extraPerm), .prefetchOk(prefetchOk),
    .irqClear(irqClear), .outPass(outPass), .outFlush(outFlush),
    .outAddr(outAddr), .outPriv(outPriv), .outDtype(outDtype),
    .outDir(outDir), .outPfable(outPfable), .irq(irq),
    .causeReg(causeReg), .faultCount(faultCount)
  );

  // {priv[2], dtype0, dir, pfable, perm[6], extra[4], pfOk, expPass, expCause[6]}
  localparam int NV = 21;
  localparam logic [22:0] VECS [NV] = '{
    {2'b00,1'b0,1'b1,1'b0,6'b000001,4'b0001,1'b1,1'b1,6'b000000}, // R1 user read ok
    {2'b00,1'b0,1'b1,1'b0,6'b111110,4'b0001,1'b1,1'b0,6'b000001}, // R1 user read denied
    {2'b01,1'b0,1'b1,1'b0,6'b001000,4'b0001,1'b1,1'b1,6'b000000}, // R1 sup read ok
    {2'b01,1'b0,1'b0,1'b0,6'b010000,4'b0001,1'b1,1'b1,6'b000000}, // R1 sup write ok
    {2'b01,1'b0,1'b0,1'b0,6'b101111,4'b0001,1'b1,1'b0,6'b000001}, // R1 sup write denied
    {2'b00,1'b1,1'b1,1'b0,6'b000100,4'b0001,1'b1,1'b1,6'b000000}, // R1 user fetch ok
    {2'b01,1'b1,1'b1,1'b0,6'b100000,4'b0001,1'b1,1'b1,6'b000000}, // R1 sup fetch ok
    {2'b01,1'b1,1'b1,1'b0,6'b011111,4'b0001,1'b1,1'b0,6'b000001}, // R1 sup fetch denied
    {2'b00,1'b1,1'b0,1'b0,6'b111111,4'b0001,1'b1,1'b0,6'b000001}, // R2 undefined type
    {2'b00,1'b0,1'b1,1'b0,6'b111111,4'b0000,1'b1,1'b0,6'b000010}, // R3 user denied
    {2'b01,1'b0,1'b1,1'b0,6'b111111,4'b0000,1'b1,1'b1,6'b000000}, // R3 sup unaffected
    {2'b00,1'b0,1'b0,1'b0,6'b111111,4'b0011,1'b1,1'b0,6'b000100}, // R4 write denied
    {2'b00,1'b0,1'b1,1'b0,6'b111111,4'b0011,1'b1,1'b1,6'b000000}, // R4 read unaffected
    {2'b01,1'b1,1'b1,1'b0,6'b111111,4'b0101,1'b1,1'b0,6'b001000}, // R5 fetch denied
    {2'b01,1'b1,1'b1,1'b0,6'b111111,4'b1001,1'b1,1'b0,6'b010000}, // R6 sup fetch denied
    {2'b00,1'b1,1'b1,1'b0,6'b111111,4'b1001,1'b1,1'b1,6'b000000}, // R6 user fetch unaffected
    {2'b00,1'b0,1'b1,1'b1,6'b111111,4'b0001,1'b0,1'b0,6'b100000}, // R7 prefetch denied
    {2'b00,1'b0,1'b1,1'b1,6'b111111,4'b0001,1'b1,1'b1,6'b000000}, // R7 prefetch allowed
    {2'b00,1'b0,1'b0,1'b1,6'b000000,4'b0010,1'b0,1'b0,6'b100111}, // R9 several causes
    {2'b01,1'b1,1'b1,1'b0,6'b011111,4'b1101,1'b1,1'b0,6'b011001}, // R9 several causes
    {2'b10,1'b1,1'b1,1'b0,6'b000100,4'b1000,1'b1,1'b0,6'b010000}  // R6 priv 2: nonzero, user grants
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic drive(input logic [22:0] v, input logic [31:0] a, input logic clr);
    inPriv = v[22:21];
    inDtype = {1'b0, v[20]};
    inDir = v[19];
    inPfable = v[18];
    permBits = v[17:12];
    extraPerm = v[11:8];
    prefetchOk = v[7];
    inAddr = a;
    inValid = 1'b1;
    irqClear = clr;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    irqClear = 1'b0;
  endtask

  task automatic pulseClear();
    irqClear = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irqClear = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  localparam logic [22:0] USER_DENY = {2'b00,1'b0,1'b1,1'b0,6'b111111,4'b0000,1'b1,1'b0,6'b000010};
  localparam logic [22:0] WRITE_DENY = {2'b00,1'b0,1'b0,1'b0,6'b111111,4'b0011,1'b1,1'b0,6'b000100};
  localparam logic [22:0] GOOD_READ = {2'b00,1'b0,1'b1,1'b0,6'b111111,4'b0001,1'b1,1'b1,6'b000000};
  localparam logic [22:0] FETCH_DENY = {2'b01,1'b1,1'b1,1'b0,6'b111111,4'b0101,1'b1,1'b0,6'b001000};

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12 pass", {31'b0, outPass}, 0);
    check("R12 flush", {31'b0, outFlush}, 0);
    check("R12 irq", {31'b0, irq}, 0);
    check("R12 cause", {26'b0, causeReg}, 0);
    check("R12 count", {28'b0, faultCount}, 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 idle pass", {31'b0, outPass}, 0);
    check("R8 idle flush", {31'b0, outFlush}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      logic [31:0] a;
      v = VECS[i];
      a = 32'h4000_0000 + 32'(i) * 32'h40;
      drive(v, a, 1'b0);
      check($sformatf("vec%0d R1-side pass", i), {31'b0, outPass}, {31'b0, v[6]});
      check($sformatf("vec%0d R8 flush", i), {31'b0, outFlush}, {31'b0, !v[6]});
      check($sformatf("vec%0d R8 addr", i), outAddr, a);
      check($sformatf("vec%0d R8 attrs", i), {26'b0, outPriv, outDtype, outDir, outPfable},
            {26'b0, v[22:21], 1'b0, v[20], v[19], v[18]});
      check($sformatf("vec%0d R9 irq", i), {31'b0, irq}, {31'b0, !v[6]});
      check($sformatf("vec%0d R9 cause", i), {26'b0, causeReg}, {26'b0, v[5:0]});
      pulseClear();
      check($sformatf("vec%0d R11 cleared", i), {31'b0, irq}, 0);
    end

    // R10 later faults counted, cause kept
    drive(USER_DENY, 32'h10, 1'b0);
    drive(WRITE_DENY, 32'h20, 1'b0);
    drive(GOOD_READ, 32'h30, 1'b0);
    check("R8 pass after faults", {31'b0, outPass}, 1);
    drive(FETCH_DENY, 32'h40, 1'b0);
    check("R10 cause kept", {26'b0, causeReg}, 32'h02);
    check("R10 count", {28'b0, faultCount}, 2);
    check("R10 irq held", {31'b0, irq}, 1);
    for (int k = 0; k < 20; k++) drive(WRITE_DENY, 32'h50, 1'b0);
    check("R10 saturate", {28'b0, faultCount}, 15);

    // R11 clear coinciding with a new fault
    drive(WRITE_DENY, 32'h60, 1'b1);
    check("R11 coincide irq", {31'b0, irq}, 1);
    check("R11 coincide cause", {26'b0, causeReg}, 32'h04);
    check("R11 coincide count", {28'b0, faultCount}, 0);
    pulseClear();
    check("R11 clear irq", {31'b0, irq}, 0);
    check("R11 clear cause", {26'b0, causeReg}, 0);
    check("R11 clear count", {28'b0, faultCount}, 0);
    pulseClear();
    check("R11 idle clear", {31'b0, irq}, 0);

    // R8 back-to-back transactions
    inPriv = 2'b00; inDtype = 2'b00; inDir = 1'b1; inPfable = 1'b0;
    permBits = 6'b111111; extraPerm = 4'b0001; prefetchOk = 1'b1;
    inAddr = 32'hA0; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 burst first pass", {31'b0, outPass}, 1);
    check("R8 burst first addr", outAddr, 32'hA0);
    inAddr = 32'hB0; extraPerm = 4'b0000;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check("R3 burst second flush", {31'b0, outFlush}, 1);
    check("R8 burst second addr", outAddr, 32'hB0);
    @(posedge clk);
    @(negedge clk);
    check("R8 burst idle", {30'b0, outPass, outFlush}, 0);

    summary();
    $finish;
  end
endmodule